// File: doc/BRIEF.md
# Nonvolatile Memory Write Controller

This block is the register-side sequencer for write and erase operations to an on-chip nonvolatile store. A CPU reaches it through a small byte-wide register bus. It selects the target space: data EEPROM, program memory, or the configuration space, which overrides the other two. It guards the start command with a two-key unlock sequence and a write-enable bit. It then hands a single operation to a behavioural array stub that stays busy for a fixed number of cycles. When the operation completes, the block presents one commit pulse with the space, the address and the data.

Program-memory writes are assembled in a bank of byte-wide holding latches. Each table write stores the table latch into the holding byte that the low pointer bits select. A program write commits the whole bank as one row, and the bank then refills with 0xFF. The start bit can be set by software but is cleared only when the operation finishes. A completion flag stays set until software clears it. An external or watchdog reset that arrives while an operation is running sets a sticky error flag, which only power-on reset or software clears.

Register addresses: 0 control, 1 unlock (no storage), 2 pointer low byte, 3 pointer high byte, 4 data byte, 5 table latch, 6 table-write strobe (write only, reads 0), 7 holding-byte view (the holding byte selected by pointer bits [2:0]). Control bits: [0] start, [1] write enable, [2] erase enable, [3] error, [4] done flag, [5] configuration select, [6] program target, [7] busy (read only).

Top module: `nvm_write_ctrl`

## Requirements
- R1: After power-on reset, the control register reads 0x00, the pointer, data and table latch registers read 0x00, and every holding byte reads 0xFF. A write to the pointer, data or table latch register reads back the written value.
- R2: The unlock register (address 1) always reads 0x00, including just after 0x55 or 0xAA is written to it.
- R3: A write of control bit 0 = 1 starts an operation only when three conditions hold: the two bus writes just before it were 0x55 and then 0xAA to the unlock register, write enable (bit 1) was already set, and no operation is running. Otherwise the request is ignored: the start bit stays 0 and no commit pulse occurs.
- R4: After acceptance, the start bit and the busy bit (bit 7) read 1 for exactly BUSY_CYCLES cycles, and writing 0 to bit 0 does not clear the start bit.
- R5: At completion the start bit returns to 0, the done flag (bit 4) becomes 1, and mem_strobe is high for exactly one cycle.
- R6: The done flag stays set until a control write with bit 4 = 0. Writing bit 4 = 1 has no effect.
- R7: mem_space is 2 (configuration) when configuration select was set at start, regardless of bit 6. Otherwise it is 1 (program) when bit 6 was set, and 0 (data EEPROM) when it was clear.
- R8: With erase enable set at start, the commit has mem_erase = 1 and mem_data all ones. A program erase uses the pointer with its low 3 bits cleared as the address.
- R9: A write to address 6 copies the table latch into the holding byte that pointer bits [2:0] select, and it can be read at address 7.
- R10: A program write commits holding byte i on mem_data[8i+7:8i], at mem_addr = pointer with its low 3 bits cleared. Afterwards all holding bytes read 0xFF. A data write commits the data byte on mem_data[7:0] at the full pointer.
- R11: An external reset during an operation sets the error bit (bit 3), clears the start bit and the registers, and suppresses the commit. The error bit survives later external resets and is cleared by power-on reset.
- R12: An external reset with no operation running leaves the error bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous active-low power-on reset, clears everything |
| ext_rst_n | input | 1 | Synchronous active-low external/watchdog reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address, also selects read data |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for bus_addr |
| mem_strobe | output | 1 | One-cycle commit pulse at completion |
| mem_space | output | 2 | 0 data EEPROM, 1 program, 2 configuration |
| mem_erase | output | 1 | Committed operation is an erase |
| mem_addr | output | 16 | Committed address |
| mem_data | output | 64 | Committed data, byte i in bits 8i+7:8i |

## Verification
The assertions watch, on every cycle, that the start bit is never dropped before completion unless a reset intervenes, and that it only rises after a start write. They also check that every fall of the start bit without reset comes with a one-cycle commit pulse, that the done and error flags stay sticky until a clearing write, that a reset during an operation sets the error flag, and that the unlock register reads zero. Only the bench scenarios can show the rest: the exact busy length, the rejection of broken unlock sequences, the space and address chosen for each mode, the ordering of the holding bytes in a committed row with the refill to 0xFF afterwards, and the loss of an interrupted commit.

// File: rtl/nvm_pkg.sv
// Package: shared types and register addresses for the nonvolatile write controller.
// Assumes a byte-wide register bus with a 3-bit address.
package nvm_pkg;

    typedef enum logic [1:0] {
        SPACE_DATA = 2'd0,
        SPACE_PROG = 2'd1,
        SPACE_CFG  = 2'd2
    } nvm_space_e;

    typedef enum logic [1:0] {
        UL_IDLE  = 2'd0,
        UL_HALF  = 2'd1,
        UL_ARMED = 2'd2
    } unlock_state_e;

    localparam logic [2:0] REG_CTRL   = 3'd0;
    localparam logic [2:0] REG_UNLOCK = 3'd1;
    localparam logic [2:0] REG_PTRL   = 3'd2;
    localparam logic [2:0] REG_PTRH   = 3'd3;
    localparam logic [2:0] REG_DATA   = 3'd4;
    localparam logic [2:0] REG_TLAT   = 3'd5;
    localparam logic [2:0] REG_TBLWR  = 3'd6;
    localparam logic [2:0] REG_HVIEW  = 3'd7;

    localparam int CB_GO    = 0;
    localparam int CB_WEN   = 1;
    localparam int CB_ERASE = 2;
    localparam int CB_ERR   = 3;
    localparam int CB_DONE  = 4;
    localparam int CB_CFG   = 5;
    localparam int CB_PROG  = 6;
    localparam int CB_BUSY  = 7;

endpackage

// File: rtl/nvm_unlock_seq.sv
// Module: two-key unlock detector.
// Tracks consecutive bus writes; arms after KEY_A then KEY_B to the unlock
// register. Any bus write consumes the armed state. Idle cycles do not break it.
// Assumes one bus write per cycle at most.
module nvm_unlock_seq
    import nvm_pkg::*;
#(
    parameter int           BYTE_W = 8,
    parameter logic [7:0]   KEY_A  = 8'h55,
    parameter logic [7:0]   KEY_B  = 8'hAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [2:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic              armed
);

    unlock_state_e state_q;
    logic          hit_a;
    logic          hit_b;

    // Decode the two key writes.
    always_comb begin
        hit_a = (addr == REG_UNLOCK) && (wdata == BYTE_W'(KEY_A));
        hit_b = (addr == REG_UNLOCK) && (wdata == BYTE_W'(KEY_B));
    end

    // Advance the sequence on every bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= UL_IDLE;
        end else if (wr) begin
            case (state_q)
                UL_IDLE:  state_q <= hit_a ? UL_HALF : UL_IDLE;
                UL_HALF:  state_q <= hit_b ? UL_ARMED : (hit_a ? UL_HALF : UL_IDLE);
                default:  state_q <= hit_a ? UL_HALF : UL_IDLE;
            endcase
        end
    end

    assign armed = (state_q == UL_ARMED);

endmodule

// File: rtl/nvm_hold_bank.sv
// Module: bank of byte-wide holding latches for program-row writes.
// A table write loads one byte chosen by idx; clr refills every byte with
// FILL. clr has priority over a same-cycle load.
module nvm_hold_bank #(
    parameter int         N_HOLD = 8,
    parameter int         BYTE_W = 8,
    parameter logic [7:0] FILL   = 8'hFF,
    localparam int        IDX_W  = $clog2(N_HOLD)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [IDX_W-1:0]         idx,
    input  logic [BYTE_W-1:0]        wdata,
    input  logic                     clr,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic [BYTE_W-1:0]        rd_data,
    output logic [N_HOLD*BYTE_W-1:0] flat
);

    logic [BYTE_W-1:0] hold_q [N_HOLD];

    for (genvar gi = 0; gi < N_HOLD; gi++) begin : g_byte
        // Hold one byte: refill on reset or clear, load on a matching table write.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                hold_q[gi] <= BYTE_W'(FILL);
            end else if (load && (idx == IDX_W'(gi))) begin
                hold_q[gi] <= wdata;
            end
        end
        assign flat[gi*BYTE_W +: BYTE_W] = hold_q[gi];
    end

    assign rd_data = hold_q[rd_idx];

endmodule

// File: rtl/nvm_array_stub.sv
// Module: behavioural stand-in for the array's busy time.
// A go pulse starts a BUSY_CYCLES-long busy window; done is high in its last
// cycle. Assumes BUSY_CYCLES >= 2 and that go is not raised while busy.
module nvm_array_stub #(
    parameter int  BUSY_CYCLES = 6,
    localparam int CNT_W       = $clog2(BUSY_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy,
    output logic done
);

    logic [CNT_W-1:0] cnt_q;

    // Load the busy window on go, count it down otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (go) begin
            cnt_q <= CNT_W'(BUSY_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/nvm_write_ctrl.sv
// Module: nonvolatile write controller top.
// Holds the control, pointer, data and table-latch registers. Gates start on
// the unlock sequence and write enable, latches the operation, and times it
// with the array stub. At completion it pulses mem_strobe with the latched
// space, address and data. por_n clears everything. ext_rst_n clears all
// but the error flag, which it sets when an operation is running.
// Assumes a 16-bit pointer made of two byte registers.
module nvm_write_ctrl
    import nvm_pkg::*;
#(
    parameter int  N_HOLD      = 8,
    parameter int  BYTE_W      = 8,
    parameter int  BUSY_CYCLES = 6,
    localparam int IDX_W       = $clog2(N_HOLD),
    localparam int ADDR_W      = 2 * BYTE_W,
    localparam int ROW_W       = N_HOLD * BYTE_W
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ext_rst_n,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              mem_strobe,
    output logic [1:0]        mem_space,
    output logic              mem_erase,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ROW_W-1:0]  mem_data
);

    logic              rst_sys_n;
    logic              wr_ctrl;
    logic              wr_tbl;
    logic              armed;
    logic              accept;
    logic              op_busy;
    logic              op_done;

    logic              go_q;
    logic              wen_q;
    logic              erase_q;
    logic              err_q;
    logic              flag_q;
    logic              cfg_q;
    logic              prog_q;
    logic [BYTE_W-1:0] ptrl_q;
    logic [BYTE_W-1:0] ptrh_q;
    logic [BYTE_W-1:0] data_q;
    logic [BYTE_W-1:0] tlat_q;

    logic [ADDR_W-1:0] ptr_full;
    logic [ADDR_W-1:0] row_addr;
    logic [BYTE_W-1:0] hold_rd;
    logic [ROW_W-1:0]  hold_flat;
    logic              hold_clr;

    nvm_space_e        sel_space;
    logic [ADDR_W-1:0] sel_addr;
    logic [ROW_W-1:0]  sel_data;

    nvm_space_e        op_space_q;
    logic              op_erase_q;
    logic [ADDR_W-1:0] op_addr_q;
    logic [ROW_W-1:0]  op_data_q;
    logic              strobe_q;

    // Combine the two reset sources for everything but the error flag.
    assign rst_sys_n = por_n && ext_rst_n;

    // Decode bus writes and the start acceptance condition.
    always_comb begin
        wr_ctrl = bus_wr && (bus_addr == REG_CTRL);
        wr_tbl  = bus_wr && (bus_addr == REG_TBLWR);
        accept  = wr_ctrl && bus_wdata[CB_GO] && armed && wen_q && !go_q;
    end

    nvm_unlock_seq #(
        .BYTE_W (BYTE_W)
    ) unlock_i (
        .clk   (clk),
        .rst_n (rst_sys_n),
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .armed (armed)
    );

    nvm_array_stub #(
        .BUSY_CYCLES (BUSY_CYCLES)
    ) stub_i (
        .clk   (clk),
        .rst_n (rst_sys_n),
        .go    (accept),
        .busy  (op_busy),
        .done  (op_done)
    );

    assign hold_clr = op_done && (op_space_q == SPACE_PROG) && !op_erase_q;

    nvm_hold_bank #(
        .N_HOLD (N_HOLD),
        .BYTE_W (BYTE_W)
    ) hold_i (
        .clk     (clk),
        .rst_n   (rst_sys_n),
        .load    (wr_tbl),
        .idx     (ptrl_q[IDX_W-1:0]),
        .wdata   (tlat_q),
        .clr     (hold_clr),
        .rd_idx  (ptrl_q[IDX_W-1:0]),
        .rd_data (hold_rd),
        .flat    (hold_flat)
    );

    // Start bit: set only by an accepted request, cleared only at completion or reset.
    always_ff @(posedge clk) begin
        if (!rst_sys_n) begin
            go_q <= 1'b0;
        end else if (op_done) begin
            go_q <= 1'b0;
        end else if (accept) begin
            go_q <= 1'b1;
        end
    end

    // Error flag: set by an external reset mid-operation, cleared by software or power-on.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            err_q <= 1'b0;
        end else if (!ext_rst_n) begin
            if (go_q) begin
                err_q <= 1'b1;
            end
        end else if (wr_ctrl && !bus_wdata[CB_ERR]) begin
            err_q <= 1'b0;
        end
    end

    // Done flag: set at completion, cleared by a control write with the bit low.
    always_ff @(posedge clk) begin
        if (!rst_sys_n) begin
            flag_q <= 1'b0;
        end else if (op_done) begin
            flag_q <= 1'b1;
        end else if (wr_ctrl && !bus_wdata[CB_DONE]) begin
            flag_q <= 1'b0;
        end
    end

    // Plain control bits: load on any control write.
    always_ff @(posedge clk) begin
        if (!rst_sys_n) begin
            wen_q   <= 1'b0;
            erase_q <= 1'b0;
            cfg_q   <= 1'b0;
            prog_q  <= 1'b0;
        end else if (wr_ctrl) begin
            wen_q   <= bus_wdata[CB_WEN];
            erase_q <= bus_wdata[CB_ERASE];
            cfg_q   <= bus_wdata[CB_CFG];
            prog_q  <= bus_wdata[CB_PROG];
        end
    end

    // Pointer, data and table latch registers.
    always_ff @(posedge clk) begin
        if (!rst_sys_n) begin
            ptrl_q <= '0;
            ptrh_q <= '0;
            data_q <= '0;
            tlat_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                REG_PTRL: ptrl_q <= bus_wdata;
                REG_PTRH: ptrh_q <= bus_wdata;
                REG_DATA: data_q <= bus_wdata;
                REG_TLAT: tlat_q <= bus_wdata;
                default:  ;
            endcase
        end
    end

    // Pick the space, address and data an accepted request will commit.
    always_comb begin
        ptr_full = {ptrh_q, ptrl_q};
        row_addr = ptr_full & ~ADDR_W'(N_HOLD - 1);
        if (cfg_q) begin
            sel_space = SPACE_CFG;
        end else if (prog_q) begin
            sel_space = SPACE_PROG;
        end else begin
            sel_space = SPACE_DATA;
        end
        sel_addr = (sel_space == SPACE_PROG) ? row_addr : ptr_full;
        if (erase_q) begin
            sel_data = '1;
        end else if (sel_space == SPACE_PROG) begin
            sel_data = hold_flat;
        end else begin
            sel_data = ROW_W'(data_q);
        end
    end

    // Latch the operation descriptor on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_sys_n) begin
            op_space_q <= SPACE_DATA;
            op_erase_q <= 1'b0;
            op_addr_q  <= '0;
            op_data_q  <= '0;
        end else if (accept) begin
            op_space_q <= sel_space;
            op_erase_q <= erase_q;
            op_addr_q  <= sel_addr;
            op_data_q  <= (sel_space == SPACE_PROG) && !erase_q ? hold_flat : sel_data;
        end
    end

    // Commit pulse, one cycle after the last busy cycle's edge.
    always_ff @(posedge clk) begin
        if (!rst_sys_n) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= op_done;
        end
    end

    // Register read multiplexer.
    always_comb begin
        case (bus_addr)
            REG_CTRL:  bus_rdata = {op_busy, prog_q, cfg_q, flag_q, err_q, erase_q, wen_q, go_q};
            REG_PTRL:  bus_rdata = ptrl_q;
            REG_PTRH:  bus_rdata = ptrh_q;
            REG_DATA:  bus_rdata = data_q;
            REG_TLAT:  bus_rdata = tlat_q;
            REG_HVIEW: bus_rdata = hold_rd;
            default:   bus_rdata = '0;
        endcase
    end

    assign mem_strobe = strobe_q;
    assign mem_space  = op_space_q;
    assign mem_erase  = op_erase_q;
    assign mem_addr   = op_addr_q;
    assign mem_data   = op_data_q;

endmodule

// File: rtl/nvm_write_ctrl_chk.sv
// Module: protocol checker bound to the write controller.
// Watches the start bit, the sticky flags, the commit pulse and the unlock read.
module nvm_write_ctrl_chk (
    input logic       clk,
    input logic       por_n,
    input logic       ext_rst_n,
    input logic       bus_wr,
    input logic [2:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       mem_strobe,
    input logic       go_q,
    input logic       flag_q,
    input logic       err_q,
    input logic       op_done
);

    // R4
    go_held_chk: assert property (@(posedge clk) disable iff (!por_n || !ext_rst_n)
        go_q && !op_done |=> go_q);

    // R3
    go_rise_chk: assert property (@(posedge clk) disable iff (!por_n || !ext_rst_n)
        $rose(go_q) |-> $past(bus_wr && (bus_addr == 3'd0) && bus_wdata[0]));

    // R5
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!por_n || !ext_rst_n)
        mem_strobe |=> !mem_strobe);

    // R5
    strobe_on_fall_chk: assert property (@(posedge clk) disable iff (!por_n || !ext_rst_n)
        $fell(go_q) && $past(ext_rst_n) |-> mem_strobe);

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!por_n || !ext_rst_n)
        flag_q && !(bus_wr && (bus_addr == 3'd0) && !bus_wdata[4]) |=> flag_q);

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        err_q && !(bus_wr && ext_rst_n && (bus_addr == 3'd0) && !bus_wdata[3]) |=> err_q);

    // R11
    err_set_chk: assert property (@(posedge clk) disable iff (!por_n)
        !ext_rst_n && go_q |=> err_q);

    // R2
    unlock_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        (bus_addr == 3'd1) |-> (bus_rdata == 8'h00));

endmodule

bind nvm_write_ctrl nvm_write_ctrl_chk chk_i (
    .clk        (clk),
    .por_n      (por_n),
    .ext_rst_n  (ext_rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .mem_strobe (mem_strobe),
    .go_q       (go_q),
    .flag_q     (flag_q),
    .err_q      (err_q),
    .op_done    (op_done)
);

// File: tb/nvm_write_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: register vector table, then directed operation, reset and corner tests.
module nvm_write_ctrl_tb_top;

    localparam int BUSY = 6;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        ext_rst_n = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        mem_strobe;
    logic [1:0]  mem_space;
    logic        mem_erase;
    logic [15:0] mem_addr;
    logic [63:0] mem_data;

    int n_chk = 0;
    int n_bad = 0;
    int strobe_cnt = 0;
    bit finished = 1'b0;

    nvm_write_ctrl #(.BUSY_CYCLES(BUSY)) dut_i (
        .clk        (clk),
        .por_n      (por_n),
        .ext_rst_n  (ext_rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .mem_strobe (mem_strobe),
        .mem_space  (mem_space),
        .mem_erase  (mem_erase),
        .mem_addr   (mem_addr),
        .mem_data   (mem_data)
    );

    always #4 clk = ~clk;

    always @(negedge clk) if (mem_strobe) strobe_cnt++;

    // {is_write, addr, data, expected}
    localparam logic [19:0] VEC [10] = '{
        {1'b1, 3'd2, 8'h5A, 8'h00}, {1'b0, 3'd2, 8'h00, 8'h5A},
        {1'b1, 3'd3, 8'hC3, 8'h00}, {1'b0, 3'd3, 8'h00, 8'hC3},
        {1'b1, 3'd4, 8'h7E, 8'h00}, {1'b0, 3'd4, 8'h00, 8'h7E},
        {1'b1, 3'd1, 8'h55, 8'h00}, {1'b0, 3'd1, 8'h00, 8'h00},
        {1'b1, 3'd5, 8'h9F, 8'h00}, {1'b0, 3'd5, 8'h00, 8'h9F}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 3'd0; bus_wdata = 8'h00;
    endtask

    task automatic read_reg(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = 3'd0;
    endtask

    task automatic do_start(input logic [7:0] cv);
        bus_write(3'd1, 8'h55);
        bus_write(3'd1, 8'hAA);
        bus_write(3'd0, cv | 8'h01);
    endtask

    task automatic run_op(input logic [7:0] cv, input string tag, input logic [1:0] sp,
                          input logic er, input logic [15:0] ad, input logic [63:0] dt);
        logic [7:0] r;
        bus_write(3'd0, cv & 8'hFE);
        do_start(cv);
        read_reg(3'd0, r);
        check({tag, " R4 start+busy set"}, r & 8'h81, 8'h81);
        bus_write(3'd0, cv & 8'hFE);
        read_reg(3'd0, r);
        check({tag, " R4 start not cleared by sw"}, r[0], 1'b1);
        repeat (BUSY - 2) @(negedge clk);
        read_reg(3'd0, r);
        check({tag, " R4 still busy last cycle"}, {r[7], r[0], mem_strobe}, 3'b110);
        @(negedge clk);
        check({tag, " R5 strobe"}, mem_strobe, 1'b1);
        check({tag, " R7 space"}, mem_space, sp);
        check({tag, " R8 erase"}, mem_erase, er);
        check({tag, " R10 addr"}, mem_addr, ad);
        check({tag, " R10 data"}, mem_data, dt);
        read_reg(3'd0, r);
        check({tag, " R5 start clear, flag set"}, {r[7], r[4], r[0]}, 3'b010);
        @(negedge clk);
        check({tag, " R5 strobe one cycle"}, mem_strobe, 1'b0);
    endtask

    initial begin
        logic [7:0] r;
        int s0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;

        // R1 reset state
        read_reg(3'd0, r); check("R1 ctrl after reset", r, 8'h00);
        read_reg(3'd2, r); check("R1 ptrl after reset", r, 8'h00);
        read_reg(3'd5, r); check("R1 tlat after reset", r, 8'h00);
        for (int i = 0; i < 8; i++) begin
            bus_write(3'd2, 8'(i));
            read_reg(3'd7, r);
            check("R1 holding after reset", r, 8'hFF);
        end

        // R1 R2 register vector table
        for (int i = 0; i < 10; i++) begin
            if (VEC[i][19]) bus_write(VEC[i][18:16], VEC[i][15:8]);
            else begin
                read_reg(VEC[i][18:16], r);
                check((VEC[i][18:16] == 3'd1) ? "R2 unlock reads zero" : "R1 register readback",
                      r, VEC[i][7:0]);
            end
        end

        // R3 start without unlock
        s0 = strobe_cnt;
        bus_write(3'd0, 8'h02);
        bus_write(3'd0, 8'h03);
        read_reg(3'd0, r); check("R3 no unlock ignored", r[0], 1'b0);
        // R3 broken sequence
        bus_write(3'd1, 8'h55);
        bus_write(3'd2, 8'h00);
        bus_write(3'd1, 8'hAA);
        bus_write(3'd0, 8'h03);
        read_reg(3'd0, r); check("R3 broken sequence ignored", r[0], 1'b0);
        // R3 write enable clear
        bus_write(3'd0, 8'h00);
        do_start(8'h00);
        read_reg(3'd0, r); check("R3 no write enable ignored", r[0], 1'b0);
        repeat (BUSY + 2) @(negedge clk);
        check("R3 no commit pulse", strobe_cnt, s0);

        // R10 data EEPROM write
        bus_write(3'd2, 8'h34); bus_write(3'd3, 8'h00); bus_write(3'd4, 8'hA5);
        run_op(8'h02, "data", 2'd0, 1'b0, 16'h0034, 64'hA5);

        // R6 flag stickiness
        repeat (3) @(negedge clk);
        bus_write(3'd0, 8'h12);
        read_reg(3'd0, r); check("R6 flag kept on write of 1", r[4], 1'b1);
        bus_write(3'd0, 8'h02);
        read_reg(3'd0, r); check("R6 flag cleared by write of 0", r[4], 1'b0);

        // R9 table writes into holding bytes
        bus_write(3'd3, 8'h12);
        for (int i = 0; i < 8; i++) begin
            bus_write(3'd2, 8'(8'h48 + i));
            bus_write(3'd5, 8'(8'h10 + i));
            bus_write(3'd6, 8'h00);
        end
        bus_write(3'd2, 8'h4B);
        read_reg(3'd7, r); check("R9 holding byte 3", r, 8'h13);
        read_reg(3'd6, r); check("R9 strobe reg reads zero", r, 8'h00);

        // R10 program row write
        run_op(8'h42, "prog", 2'd1, 1'b0, 16'h1248, 64'h1716151413121110);
        for (int i = 0; i < 8; i++) begin
            bus_write(3'd2, 8'(8'h48 + i));
            read_reg(3'd7, r);
            check("R10 holding refilled", r, 8'hFF);
        end

        // R7 configuration overrides program target
        bus_write(3'd2, 8'h07); bus_write(3'd3, 8'h00); bus_write(3'd4, 8'h3C);
        run_op(8'h62, "cfg", 2'd2, 1'b0, 16'h0007, 64'h3C);

        // R8 program erase
        bus_write(3'd2, 8'h55); bus_write(3'd3, 8'h12);
        run_op(8'h46, "erase", 2'd1, 1'b1, 16'h1250, 64'hFFFF_FFFF_FFFF_FFFF);

        // R11 external reset during an operation
        bus_write(3'd0, 8'h02);
        s0 = strobe_cnt;
        do_start(8'h02);
        repeat (2) @(negedge clk);
        ext_rst_n = 1'b0;
        @(negedge clk);
        ext_rst_n = 1'b1;
        read_reg(3'd0, r); check("R11 error set, start cleared", r, 8'h08);
        read_reg(3'd2, r); check("R11 pointer cleared", r, 8'h00);
        repeat (BUSY + 2) @(negedge clk);
        check("R11 aborted commit suppressed", strobe_cnt, s0);
        ext_rst_n = 1'b0; @(negedge clk); ext_rst_n = 1'b1;
        read_reg(3'd0, r); check("R11 error survives ext reset", r[3], 1'b1);
        por_n = 1'b0; @(negedge clk); por_n = 1'b1;
        read_reg(3'd0, r); check("R11 error cleared by power-on", r[3], 1'b0);

        // R12 idle external reset
        bus_write(3'd0, 8'h02);
        ext_rst_n = 1'b0; @(negedge clk); ext_rst_n = 1'b1;
        read_reg(3'd0, r); check("R12 idle reset no error", r, 8'h00);

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule